// File: doc/BRIEF.md
# Dual-Bank Power-of-Two Clock Divider

This block takes one input clock and produces two divided clocks, bank A and bank B. Each bank has its own 2-bit ratio select. Bank A divides by 1, 2, 4 or 8, and bank B divides by 2, 4, 8 or 16. Both banks tap a single shared up-counter, so every edge that the two outputs have in common falls on the same input clock edge. The divided outputs are registered, and the divide-by-1 path is the input clock gated by an enable register that changes only on the falling edge.

A common active-low enable stops and restarts the divider. It is sampled on the falling edge, so it can only change what the outputs do while the input clock is low. When the block is disabled, a divided output that is in its high half completes that half before it parks low. The counter then holds its value, and counting resumes from that value on re-enable. A synchronous active-high reset clears the counter, forces both outputs low and loads the selects. A new select value is adopted only when the shared counter wraps, which means a period is never cut part-way.

Top module: `cdv_dual_divider`

## Requirements
- R1: Bank A select encoding is 0 → ÷1, 1 → ÷2, 2 → ÷4, 3 → ÷8. A ÷n output (n ≥ 2) is high for n/2 input cycles and then low for n/2 input cycles. In ÷1 it follows the input clock.
- R2: Bank B select encoding is 0 → ÷2, 1 → ÷4, 2 → ÷8, 3 → ÷16, with the same 50 % duty as R1.
- R3: Both banks derive from one counter that advances by one on each rising edge while the divider is active. Every divided high phase starts on the rising edge at which the counter leaves a multiple of the ratio, so periods of both banks restart together when the counter leaves zero.
- R4: A high pulse on a divided output is never shorter than half its period, whatever the timing of the enable.
- R5: The enable (`en_n`, active low) is sampled on the falling clock edge. When it is deasserted, each divided output finishes its high half and then stays low, and the counter holds. On reassertion, counting continues from the held value without a reset.
- R6: While `rst` is high, the counter is cleared and both outputs are low. On the first rising edge that follows a falling edge at which `rst` is low and `en_n` is low, both outputs go high.
- R7: A select change is applied only on the rising edge at which the counter wraps from all ones to zero. Until then the bank keeps its previous ratio.
- R8: The ÷1 output of bank A is low whenever the input clock is low or the enable sampled at the last falling edge is deasserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Common active-low enable, sampled on the falling edge |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| out_a | output | 1 | Bank A divided clock |
| out_b | output | 1 | Bank B divided clock |

## Verification
The assertions assume that `rst`, `en_n` and the selects are synchronous to `clk_in`. They also assume that reset is held through at least one falling edge so the enable register starts from a known value. The pulse-length property relies on a select being adopted only at a wrap, which is the point where every high phase starts. The stimulus changes all inputs in the low phase, well before the next rising edge. The one exception is the reset release, which is driven just after a rising edge so the following falling edge sees it. Random enable toggling and select changes then move the counter through every freeze and resume position.

// File: rtl/cdv_pkg.sv
`timescale 1ns/1ps
package cdv_pkg;

  // Counter bits a bank needs: its largest exponent.
  function automatic int tap_bits(int sel_w, int base);
    int top_exp;
    top_exp = base + (1 << sel_w) - 1;
    return (top_exp < 1) ? 1 : top_exp;
  endfunction

  // Shared chain width: the widest of the two banks.
  function automatic int chain_bits(int sel_w, int base_a, int base_b);
    int wa;
    int wb;
    wa = tap_bits(sel_w, base_a);
    wb = tap_bits(sel_w, base_b);
    return (wa > wb) ? wa : wb;
  endfunction

endpackage

// File: rtl/cdv_run_sampler.sv
`timescale 1ns/1ps
// Enable register on the falling edge: its output only moves while clk is low.
module cdv_run_sampler (
  input  logic clk,
  input  logic rst,
  input  logic en_n,
  output logic run
);
  always_ff @(negedge clk) begin
    if (rst) run <= 1'b0;
    else     run <= ~en_n;
  end
endmodule

// File: rtl/cdv_chain.sv
`timescale 1ns/1ps
// Shared up-counter that every bank taps.
module cdv_chain #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  assign wrap = &cnt;
endmodule

// File: rtl/cdv_bank.sv
`timescale 1ns/1ps
// One output bank: picks a counter tap by exponent BASE + sel.
module cdv_bank #(
  parameter int SEL_W = 2,
  parameter int BASE  = 0,
  parameter int TAP_W = cdv_pkg::tap_bits(SEL_W, BASE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             adv,
  input  logic             wrap,
  input  logic [TAP_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             q_out,
  output logic             hi
);
  localparam int NSEL = 1 << SEL_W;

  logic [SEL_W-1:0] sel_eff;
  logic             q_reg;
  logic [NSEL-1:0]  tap_hi;   // counter is in the first half of the period
  logic [NSEL-1:0]  tap_st;   // counter is at the start of the period

  generate
    for (genvar i = 0; i < NSEL; i++) begin : g_tap
      localparam int E = BASE + i;
      if (E == 0) begin : g_pass
        assign tap_hi[i] = 1'b0;
        assign tap_st[i] = 1'b0;
      end else begin : g_div
        assign tap_hi[i] = ~cnt[E-1];
        assign tap_st[i] = (cnt[E-1:0] == '0);
      end
    end
  endgenerate

  // Ratio is adopted only at the shared wrap.
  always_ff @(posedge clk) begin
    if (rst)              sel_eff <= sel;
    else if (adv && wrap) sel_eff <= sel;
  end

  // A high phase may only begin at a period start while running, and it
  // always runs to its natural end, so no pulse is shortened.
  always_ff @(posedge clk) begin
    if (rst)      q_reg <= 1'b0;
    else if (adv) q_reg <= (q_reg & tap_hi[sel_eff]) | (run & tap_st[sel_eff]);
  end

  assign hi = q_reg;

  generate
    if (BASE == 0) begin : g_bypass
      logic by1;
      assign by1   = (sel_eff == '0);
      assign q_out = by1 ? (clk & run) : q_reg;
    end else begin : g_nobypass
      assign q_out = q_reg;
    end
  endgenerate
endmodule

// File: rtl/cdv_dual_divider.sv
`timescale 1ns/1ps
module cdv_dual_divider #(
  parameter int SEL_W  = 2,
  parameter int A_BASE = 0,
  parameter int B_BASE = 1
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             en_n,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  output logic             out_a,
  output logic             out_b
);
  localparam int CNT_W = cdv_pkg::chain_bits(SEL_W, A_BASE, B_BASE);
  localparam int A_TAP = cdv_pkg::tap_bits(SEL_W, A_BASE);
  localparam int B_TAP = cdv_pkg::tap_bits(SEL_W, B_BASE);

  logic             run;
  logic             adv;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic             qa_hi;
  logic             qb_hi;

  cdv_run_sampler u_run (
    .clk (clk_in),
    .rst (rst),
    .en_n(en_n),
    .run (run)
  );

  // Keep counting while enabled or while a bank is still finishing a high phase.
  assign adv = run | qa_hi | qb_hi;

  cdv_chain #(.CNT_W(CNT_W)) u_chain (
    .clk (clk_in),
    .rst (rst),
    .adv (adv),
    .cnt (cnt),
    .wrap(wrap)
  );

  cdv_bank #(.SEL_W(SEL_W), .BASE(A_BASE), .TAP_W(A_TAP)) u_bank_a (
    .clk  (clk_in),
    .rst  (rst),
    .run  (run),
    .adv  (adv),
    .wrap (wrap),
    .cnt  (cnt[A_TAP-1:0]),
    .sel  (sel_a),
    .q_out(out_a),
    .hi   (qa_hi)
  );

  cdv_bank #(.SEL_W(SEL_W), .BASE(B_BASE), .TAP_W(B_TAP)) u_bank_b (
    .clk  (clk_in),
    .rst  (rst),
    .run  (run),
    .adv  (adv),
    .wrap (wrap),
    .cnt  (cnt[B_TAP-1:0]),
    .sel  (sel_b),
    .q_out(out_b),
    .hi   (qb_hi)
  );
endmodule

// File: rtl/cdv_dual_divider_chk.sv
`timescale 1ns/1ps
module cdv_dual_divider_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             adv,
  input logic [CNT_W-1:0] cnt,
  input logic             qa_hi,
  input logic             qb_hi
);
  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = cnt + 1'b1;

  // R3: the shared counter steps by one whenever it is active
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cnt == $past(cnt_inc)));

  // R3: a high phase starts on an even count, so the count after it is odd
  p_rise_odd_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(qa_hi) || $rose(qb_hi)) |-> cnt[0]);

  // R5: with no enable and nothing draining, the counter holds
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !qa_hi && !qb_hi) |=> $stable(cnt));

  // R5: once parked, the outputs stay low until re-enabled
  p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !qa_hi && !qb_hi) |=> (!qa_hi && !qb_hi));

  // R6: the first active edge after reset drives bank B high
  p_first_rise_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && run) |=> qb_hi);
endmodule

module cdv_bank_chk #(
  parameter int SEL_W = 2,
  parameter int BASE  = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             adv,
  input logic             wrap,
  input logic             q_reg,
  input logic [SEL_W-1:0] sel_eff
);
  int len;

  function automatic int half_len(int s);
    return 1 << (BASE + s - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)        len <= 0;
    else if (q_reg) len <= len + 1;
    else            len <= 0;
  end

  // R4: every completed high pulse lasts exactly half the period
  p_full_high_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(q_reg) && !$past(rst)) |-> (len == half_len(int'($past(sel_eff)))));

  // R7: the adopted ratio changes only at a wrap
  p_sel_at_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(adv && wrap)) |-> $stable(sel_eff));
endmodule

bind cdv_dual_divider cdv_dual_divider_chk #(.CNT_W(CNT_W)) i_top_chk (
  .clk  (clk_in),
  .rst  (rst),
  .run  (run),
  .adv  (adv),
  .cnt  (cnt),
  .qa_hi(qa_hi),
  .qb_hi(qb_hi)
);

bind cdv_bank cdv_bank_chk #(.SEL_W(SEL_W), .BASE(BASE)) i_bank_chk (
  .clk    (clk),
  .rst    (rst),
  .adv    (adv),
  .wrap   (wrap),
  .q_reg  (q_reg),
  .sel_eff(sel_eff)
);

// File: tb/test_cdv_dual_divider.sv
`timescale 1ns/1ps
module test_cdv_dual_divider;
  logic       clk   = 1'b0;
  logic       rst   = 1'b1;
  logic       en_n  = 1'b1;
  logic [1:0] sel_a = 2'd0;
  logic [1:0] sel_b = 2'd0;
  logic       out_a;
  logic       out_b;

  cdv_dual_divider i_cdv_dual_divider (
    .clk_in(clk),
    .rst   (rst),
    .en_n  (en_n),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .out_a (out_a),
    .out_b (out_b)
  );

  always #2.5 clk = ~clk;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string ta = "R1";
  string tb_ = "R2";
  bit    align_on = 0;
  bit    len_on = 0;
  bit    armed = 0;
  int    hi_len = 0;
  int    rise_sb = 0;

  // Reference: phase position within each bank's period.
  bit m_run = 0;
  int m_cnt = 0;
  bit m_qa = 0;
  bit m_qb = 0;
  int m_sa = 0;
  int m_sb = 0;

  function automatic bit in_high(int c, int r);
    return (c % r) < (r / 2);
  endfunction

  function automatic bit at_start(int c, int r);
    return (c % r) == 0;
  endfunction

  always @(negedge clk) m_run = !en_n && !rst;

  always @(posedge clk) begin
    int ra;
    int rb;
    if (rst) begin
      m_cnt = 0; m_qa = 0; m_qb = 0;
      m_sa = int'(sel_a); m_sb = int'(sel_b);
    end else if (m_run || m_qa || m_qb) begin
      if (m_sa == 0) m_qa = 0;
      else begin
        ra = 1 << m_sa;
        m_qa = (m_qa && in_high(m_cnt, ra)) || (m_run && at_start(m_cnt, ra));
      end
      rb = 2 << m_sb;
      m_qb = (m_qb && in_high(m_cnt, rb)) || (m_run && at_start(m_cnt, rb));
      if (m_cnt == 15) begin
        m_sa = int'(sel_a); m_sb = int'(sel_b);
      end
      m_cnt = (m_cnt + 1) % 16;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
    chk(ta, out_a, (m_sa == 0) ? m_run : m_qa, "bank A after rising edge");
    chk(tb_, out_b, m_qb, "bank B after rising edge");
    if (align_on && m_cnt == 1) begin
      chk("R3", out_b, 1'b1, "bank B restarts with counter");
      if (m_sa != 0) chk("R3", out_a, 1'b1, "bank A restarts with counter");
    end
    if (len_on) begin
      if (out_b) begin
        if (armed) begin
          if (hi_len == 0) rise_sb = m_sb;
          hi_len++;
        end
      end else begin
        if (armed && hi_len > 0) chk_int("R4", hi_len, (2 << rise_sb) / 2, "bank B high pulse length");
        hi_len = 0;
        armed = 1;
      end
    end
    @(negedge clk); #2;
    chk((m_sa == 0) ? string'("R8") : ta, out_a, (m_sa == 0) ? 1'b0 : m_qa, "bank A in low phase");
    chk(tb_, out_b, m_qb, "bank B in low phase");
  endtask

  initial begin
    void'($urandom(32'd7321));
    en_n = 1'b0;
    @(negedge clk); #2;
    ta = "R6"; tb_ = "R6";
    repeat (3) cyc();

    // Reset release just after a rising edge; next falling edge sees it.
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #2;
    chk("R6", out_b, 1'b1, "first edge after reset, bank B");
    chk("R6", out_a, 1'b1, "first edge after reset, bank A div1");
    @(negedge clk); #2;
    chk("R6", out_a, 1'b0, "bank A div1 low phase");

    // All select combinations, changed mid-stream.
    align_on = 1;
    for (int sa = 0; sa < 4; sa++) begin
      for (int sb = 0; sb < 4; sb++) begin
        sel_a = 2'(sa); sel_b = 2'(sb);
        ta = "R7"; tb_ = "R7";
        repeat (16) cyc();
        ta = "R1"; tb_ = "R2";
        repeat (20) cyc();
      end
    end
    align_on = 0;

    // Directed freeze in the middle of a long high phase.
    ta = "R5"; tb_ = "R5";
    sel_a = 2'd3; sel_b = 2'd3;
    repeat (20) cyc();
    while (m_cnt != 3) cyc();
    en_n = 1'b1;
    repeat (30) cyc();
    chk("R5", out_b, 1'b0, "parked low after drain");
    chk("R5", out_a, 1'b0, "bank A parked low after drain");
    en_n = 1'b0;
    repeat (24) cyc();

    // Random enable and select activity with pulse-length tracking.
    len_on = 1; armed = 0; hi_len = 0;
    for (int i = 0; i < 500; i++) begin
      if ($urandom % 4 == 0) en_n = ~en_n;
      if ($urandom % 16 == 0) begin
        sel_a = 2'($urandom);
        sel_b = 2'($urandom);
      end
      cyc();
    end
    len_on = 0;

    // Divide-by-one gating.
    ta = "R8"; tb_ = "R2";
    en_n = 1'b0; sel_a = 2'd0;
    repeat (20) cyc();
    en_n = 1'b1;
    repeat (6) cyc();
    @(posedge clk); #2;
    chk("R8", out_a, 1'b0, "div1 held low while disabled");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule